// File: doc/BRIEF.md
# Per-Pin Byte-Mapped GPIO Controller with Interrupt Detection

This block is a memory-mapped general-purpose I/O controller for up to 128 pins. Software sees nine byte arrays, each holding one byte per pin. They cover pin direction, the driven level, the sampled level, and the interrupt settings: enable, polarity, edge select, dual-edge, write-one-to-clear and latched status. Only bit 0 of every byte carries meaning.

Accesses use a simple synchronous register bus. A write takes effect on the clock edge that samples it. Read data appears on `bus_rdata` one cycle after the read is sampled. Pad inputs pass through a two-flop synchronizer. Each pin then detects its trigger from the synchronized level, or from that level compared with its value one cycle earlier. A pin latches its status bit whether or not its interrupt is enabled. The registered per-pin interrupt vector and the OR of that vector are both gated by enable.

Top module: `pinbank_irq_ctrl`

## Requirements
- R1: Pin n of each array lives at byte address base+n. Reads return the bit in position 0 with bits 7:1 at zero. Writes look only at write-data bit 0.
- R2: The array bases (12-bit byte address) are: direction 0x800, output 0x900, input 0xA00, enable 0xB00, polarity 0xC00, edge select 0xD00, clear 0xE00, status 0xF00 and dual-edge 0xF80.
- R3: After synchronous reset, every direction bit is 1 (input). The output, enable, polarity, edge and dual-edge bits are 0, every pad output enable is low, and the interrupt vector is zero.
- R4: A direction bit of 0 raises that pin's `pad_oe`. A direction bit of 1 lowers it. `pad_out` carries the pin's output bit.
- R5: A read of a pin's input byte returns the pad level seen through the two-flop synchronizer. A pad change is visible to a read sampled on the third rising edge after the change.
- R6: With edge select 0 the pin is level-sensitive. Polarity 1 triggers on high and polarity 0 triggers on low. While the active level persists, status is set again on the cycle after a clear.
- R7: With edge select 1 and dual-edge 0, polarity 1 triggers on a rising edge only and polarity 0 on a falling edge only. The opposite edge leaves status unchanged.
- R8: With edge select 1 and dual-edge 1, both edges trigger, whatever the polarity bit holds.
- R9: Writing 1 to a pin's clear byte clears its status. Writing 0 leaves status unchanged, and the clear array reads as 0. When a trigger and a clear hit the same cycle, status stays set.
- R10: Status latches even while enable is 0. `irq_vec[n]` is status AND enable, registered one cycle. `irq_any` is the OR of the same terms.
- R11: Writes to the input and status arrays, and to any pin index at or above PIN_COUNT, change nothing. Such indices, and addresses outside all arrays, read as 0.
- R12: Read data for an access sampled on one rising edge is presented on `bus_rdata` after that edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data (bit 0 used) |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | PIN_COUNT | Pad input levels (asynchronous) |
| pad_out | output | PIN_COUNT | Level driven to pads |
| pad_oe | output | PIN_COUNT | Pad output enable, high = drive |
| irq_vec | output | PIN_COUNT | Per-pin interrupt, status AND enable |
| irq_any | output | 1 | OR of all enabled pending interrupts |

## Verification
The hardest situation to reach from the ports is a trigger and a clear write landing on the same clock edge. The synchronizer and the previous-value register hide the exact cycle in which an edge becomes a trigger. The bench works this cycle out from the pad change: it toggles a dual-edge pin and presents the clear write on the second falling clock edge after the toggle, so both act at the same rising edge. It then confirms that status stays set. Everything else is swept across all pins of an 8-pin build: the address-map patterns, each of the five trigger modes per pin, and enable gating.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 8;

  typedef enum logic [3:0] {
    F_DIR,
    F_OUT,
    F_IN,
    F_IEN,
    F_POL,
    F_EDGE,
    F_CLR,
    F_STS,
    F_DUAL,
    F_NONE
  } field_e;

  // Region code in address bits 11:8; region 0xF splits on bit 7.
  function automatic field_e field_of(input logic [ADDR_W-1:0] a);
    field_e f;
    case (a[11:8])
      4'h8:    f = F_DIR;
      4'h9:    f = F_OUT;
      4'hA:    f = F_IN;
      4'hB:    f = F_IEN;
      4'hC:    f = F_POL;
      4'hD:    f = F_EDGE;
      4'hE:    f = F_CLR;
      4'hF:    f = a[7] ? F_DUAL : F_STS;
      default: f = F_NONE;
    endcase
    return f;
  endfunction

  function automatic logic [IDX_W-1:0] pin_of(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] p;
    if (a[11:8] == 4'hF && a[7]) p = {1'b0, a[6:0]};
    else                         p = a[7:0];
    return p;
  endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_o <= '0;
      prev_o <= '0;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
      prev_o <= sync_o;
    end
  end

  // Previous-value register follows the synchronized level by one cycle.
  AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prev_o == $past(sync_o)) else $error("prev lag broken"); // R7

endmodule

// File: rtl/pinbank_pin_cell.sv
module pinbank_pin_cell
  import pinbank_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  field_e wr_field,
  input  logic   hit,
  input  logic   wbit,
  input  logic   sync_i,
  input  logic   prev_i,
  output logic   dir_q,
  output logic   out_q,
  output logic   ien_q,
  output logic   pol_q,
  output logic   edge_q,
  output logic   dual_q,
  output logic   sts_q
);

  logic trig;
  logic clr;

  always_comb begin
    if (!edge_q)     trig = pol_q ? sync_i : ~sync_i;
    else if (dual_q) trig = sync_i ^ prev_i;
    else if (pol_q)  trig = sync_i & ~prev_i;
    else             trig = ~sync_i & prev_i;
  end

  assign clr = hit && (wr_field == F_CLR) && wbit;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b1;
      out_q  <= 1'b0;
      ien_q  <= 1'b0;
      pol_q  <= 1'b0;
      edge_q <= 1'b0;
      dual_q <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      if (hit && wr_field == F_DIR)  dir_q  <= wbit;
      if (hit && wr_field == F_OUT)  out_q  <= wbit;
      if (hit && wr_field == F_IEN)  ien_q  <= wbit;
      if (hit && wr_field == F_POL)  pol_q  <= wbit;
      if (hit && wr_field == F_EDGE) edge_q <= wbit;
      if (hit && wr_field == F_DUAL) dual_q <= wbit;
      sts_q <= trig | (sts_q & ~clr);
    end
  end

  AST_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sts_q && !clr) |=> sts_q) else $error("status dropped without clear"); // R9

  AST_LEVEL_RELATCH: assert property (@(posedge clk) disable iff (rst)
    (!edge_q && (pol_q == sync_i)) |=> sts_q) else $error("level not latched"); // R6

  AST_EDGE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ($rose(sts_q) && $past(edge_q)) |-> ($past(sync_i) != $past(prev_i)))
    else $error("edge status without edge"); // R7

  AST_DUAL_ANY: assert property (@(posedge clk) disable iff (rst)
    (edge_q && dual_q && (sync_i != prev_i)) |=> sts_q)
    else $error("dual edge missed"); // R8

endmodule

// File: rtl/pinbank_regif.sv
module pinbank_regif
  import pinbank_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [PINS-1:0]   dir_v,
  input  logic [PINS-1:0]   out_v,
  input  logic [PINS-1:0]   in_v,
  input  logic [PINS-1:0]   ien_v,
  input  logic [PINS-1:0]   pol_v,
  input  logic [PINS-1:0]   edge_v,
  input  logic [PINS-1:0]   sts_v,
  input  logic [PINS-1:0]   dual_v,
  output field_e            wr_field,
  output logic [PINS-1:0]   wr_hit,
  output logic              wr_bit,
  output logic [DATA_W-1:0] rdata
);

  field_e           acc_field;
  logic [IDX_W-1:0] acc_pin;
  logic [PINS-1:0]  sel_vec;
  logic             rbit;
  logic             unused_wdata_hi;

  assign acc_field       = field_of(bus_addr);
  assign acc_pin         = pin_of(bus_addr);
  assign wr_field        = (bus_sel && bus_wr) ? acc_field : F_NONE;
  assign wr_bit          = bus_wdata[0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:1];

  for (genvar g = 0; g < PINS; g++) begin : g_hit
    assign wr_hit[g] = (acc_pin == IDX_W'(g));
  end

  always_comb begin
    case (acc_field)
      F_DIR:   sel_vec = dir_v;
      F_OUT:   sel_vec = out_v;
      F_IN:    sel_vec = in_v;
      F_IEN:   sel_vec = ien_v;
      F_POL:   sel_vec = pol_v;
      F_EDGE:  sel_vec = edge_v;
      F_STS:   sel_vec = sts_v;
      F_DUAL:  sel_vec = dual_v;
      default: sel_vec = '0;
    endcase
    rbit = 1'b0;
    for (int i = 0; i < PINS; i++) begin
      if (acc_pin == IDX_W'(i)) rbit = sel_vec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (bus_sel && !bus_wr) rdata <= {{(DATA_W-1){1'b0}}, rbit};
  end

  AST_RDATA_NARROW: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:1] == '0) else $error("upper read bits set"); // R1

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(rdata)) else $error("rdata moved"); // R12

endmodule

// File: rtl/pinbank_irq_ctrl.sv
module pinbank_irq_ctrl
  import pinbank_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe,
  output logic [PIN_COUNT-1:0] irq_vec,
  output logic                 irq_any
);

  logic [PIN_COUNT-1:0] sync_v, prev_v;
  logic [PIN_COUNT-1:0] dir_v, out_v, ien_v, pol_v, edge_v, dual_v, sts_v;
  logic [PIN_COUNT-1:0] wr_hit;
  logic [PIN_COUNT-1:0] pend_v;
  field_e               wr_field;
  logic                 wr_bit;

  pinbank_sync #(.WIDTH(PIN_COUNT)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pad_in),
    .sync_o  (sync_v),
    .prev_o  (prev_v)
  );

  pinbank_regif #(.PINS(PIN_COUNT)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .dir_v     (dir_v),
    .out_v     (out_v),
    .in_v      (sync_v),
    .ien_v     (ien_v),
    .pol_v     (pol_v),
    .edge_v    (edge_v),
    .sts_v     (sts_v),
    .dual_v    (dual_v),
    .wr_field  (wr_field),
    .wr_hit    (wr_hit),
    .wr_bit    (wr_bit),
    .rdata     (bus_rdata)
  );

  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
    pinbank_pin_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .wr_field (wr_field),
      .hit      (wr_hit[g]),
      .wbit     (wr_bit),
      .sync_i   (sync_v[g]),
      .prev_i   (prev_v[g]),
      .dir_q    (dir_v[g]),
      .out_q    (out_v[g]),
      .ien_q    (ien_v[g]),
      .pol_q    (pol_v[g]),
      .edge_q   (edge_v[g]),
      .dual_q   (dual_v[g]),
      .sts_q    (sts_v[g])
    );
  end

  assign pend_v  = sts_v & ien_v;
  assign pad_out = out_v;
  assign pad_oe  = ~dir_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_vec <= '0;
      irq_any <= 1'b0;
    end else begin
      irq_vec <= pend_v;
      irq_any <= |pend_v;
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (irq_vec & ~$past(ien_v)) == '0) else $error("irq without enable"); // R10

  AST_IRQ_ANY_OR: assert property (@(posedge clk) disable iff (rst)
    irq_any == (irq_vec != '0)) else $error("summary mismatch"); // R10

  AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (rst)
    (wr_field == F_DIR && wr_hit != '0) |=> ((pad_oe & $past(wr_hit)) == ($past(wr_bit) ? '0 : $past(wr_hit))))
    else $error("oe not following direction write"); // R4

endmodule

// File: tb/pinbank_irq_ctrl_tb.sv
`timescale 1ns/1ps
module pinbank_irq_ctrl_tb;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pads = '0;
  logic [NP-1:0] pad_out, pad_oe, irq_vec;
  logic          irq_any;

  int n_checks = 0;
  int n_fail   = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  pinbank_irq_ctrl #(.PIN_COUNT(NP)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pads), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_vec(irq_vec), .irq_any(irq_any)
  );

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] base_of(input int k);
    case (k)
      0: return 12'h800;
      1: return 12'h900;
      2: return 12'hB00;
      3: return 12'hC00;
      4: return 12'hD00;
      default: return 12'hF80;
    endcase
  endfunction

  function automatic logic pat(input int k, input int p);
    return logic'(((p >> (k % 3)) ^ k) & 1);
  endfunction

  task automatic cfg_pin(input int p, input logic en, input logic pl,
                         input logic ed, input logic du);
    bus_write(12'hB00 + 12'(p), {7'h0, en});
    bus_write(12'hC00 + 12'(p), {7'h0, pl});
    bus_write(12'hD00 + 12'(p), {7'h0, ed});
    bus_write(12'hF80 + 12'(p), {7'h0, du});
  endtask

  task automatic read_sts(input int p, output logic [7:0] d);
    bus_read(12'hF00 + 12'(p), d);
  endtask

  initial begin
    logic [7:0] rd;
    do_reset();

    // R3: reset state
    check("R3 pad_oe after reset", pad_oe, 0);
    check("R3 irq_vec after reset", irq_vec, 0);
    for (int p = 0; p < NP; p++) begin
      bus_read(12'h800 + 12'(p), rd); check("R3 dir reset", rd, 1);
      for (int k = 1; k < 6; k++) begin
        bus_read(base_of(k) + 12'(p), rd); check("R3 cfg reset", rd, 0);
      end
    end

    // R1/R2: address map sweep, upper write bits ignored
    for (int k = 0; k < 6; k++)
      for (int p = 0; p < NP; p++)
        bus_write(base_of(k) + 12'(p), {7'h7F, pat(k, p)});
    for (int k = 0; k < 6; k++)
      for (int p = 0; p < NP; p++) begin
        bus_read(base_of(k) + 12'(p), rd);
        check("R1 R2 array readback", rd, {7'h0, pat(k, p)});
      end
    // R4: pad drive follows direction and output
    for (int p = 0; p < NP; p++) begin
      check("R4 pad_oe", pad_oe[p], !pat(0, p));
      check("R4 pad_out", pad_out[p], pat(1, p));
    end

    // R12: read data holds between reads
    bus_read(12'h900 + 12'd1, rd);
    wait_cyc(3);
    check("R12 rdata held", bus_rdata, {7'h0, pat(1, 1)});

    do_reset();

    // R11: ignored writes and unmapped reads
    bus_write(12'h800 + 12'(NP), 8'h00);
    bus_read(12'h800 + 12'(NP), rd); check("R11 out-of-range dir read", rd, 0);
    for (int p = 0; p < NP; p++) begin
      bus_read(12'h800 + 12'(p), rd); check("R11 dir untouched", rd, 1);
    end
    bus_read(12'h100, rd); check("R11 unmapped read", rd, 0);
    pads = '0; wait_cyc(2);
    bus_write(12'hA02, 8'h01);
    bus_read(12'hA02, rd); check("R11 input write ignored", rd, 0);

    // R5: input sampling sweep
    for (int k = 0; k < 16; k++) begin
      @(negedge clk) pads = NP'(k * 37 + 5);
      wait_cyc(1);
      for (int p = 0; p < NP; p++) begin
        bus_read(12'hA00 + 12'(p), rd);
        check("R5 input level", rd, {7'h0, pads[p]});
      end
    end

    // R6/R7/R8/R10: per pin, per mode
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 5; m++) begin
        logic idle;
        logic lvl;
        lvl  = (m < 2);
        idle = (m == 0 || m == 3);
        @(negedge clk) pads[p] = idle;
        case (m)
          0: cfg_pin(p, 1'b1, 1'b0, 1'b0, 1'b0);
          1: cfg_pin(p, 1'b1, 1'b1, 1'b0, 1'b0);
          2: cfg_pin(p, 1'b1, 1'b1, 1'b1, 1'b0);
          3: cfg_pin(p, 1'b1, 1'b0, 1'b1, 1'b0);
          default: cfg_pin(p, 1'b1, logic'(p & 1), 1'b1, 1'b1);
        endcase
        wait_cyc(4);
        bus_write(12'hE00 + 12'(p), 8'h01);
        wait_cyc(3);
        read_sts(p, rd); check("R6 R7 R8 idle no trigger", rd, 0);
        check("R10 irq idle", irq_vec, 0);
        check("R10 irq_any idle", irq_any, 0);
        @(negedge clk) pads[p] = ~idle;
        wait_cyc(5);
        read_sts(p, rd); check("R6 R7 R8 active trigger", rd, 1);
        check("R10 irq_vec pending", irq_vec, 1 << p);
        check("R10 irq_any pending", irq_any, 1);
        bus_write(12'hE00 + 12'(p), 8'h01);
        wait_cyc(3);
        read_sts(p, rd);
        if (lvl) check("R6 level relatch after clear", rd, 1);
        else     check("R7 R8 edge cleared", rd, 0);
        @(negedge clk) pads[p] = idle;
        wait_cyc(5);
        if (lvl) bus_write(12'hE00 + 12'(p), 8'h01);
        wait_cyc(2);
        read_sts(p, rd);
        if (m == 4) check("R8 return edge triggers", rd, 1);
        else if (lvl) check("R6 inactive level clears", rd, 0);
        else check("R7 opposite edge ignored", rd, 0);
        cfg_pin(p, 1'b0, 1'b0, 1'b1, 1'b0);
        bus_write(12'hE00 + 12'(p), 8'h01);
      end
    end

    // R10: status latches with enable low; enable releases irq
    @(negedge clk) pads[3] = 1'b0;
    cfg_pin(3, 1'b0, 1'b1, 1'b1, 1'b0);
    wait_cyc(4);
    bus_write(12'hE03, 8'h01);
    @(negedge clk) pads[3] = 1'b1;
    wait_cyc(5);
    read_sts(3, rd); check("R10 status latched while disabled", rd, 1);
    check("R10 irq masked", irq_vec, 0);
    check("R10 irq_any masked", irq_any, 0);
    bus_write(12'hB03, 8'h01);
    wait_cyc(1);
    check("R10 irq after enable", irq_vec, 8'h08);
    bus_write(12'hB03, 8'h00);

    // R9: clear write of 0, clear array read, status write ignored
    bus_write(12'hE03, 8'h00);
    read_sts(3, rd); check("R9 zero clear no effect", rd, 1);
    bus_read(12'hE03, rd); check("R9 clear reads zero", rd, 0);
    bus_write(12'hF03, 8'h00);
    read_sts(3, rd); check("R11 status write ignored", rd, 1);

    // R9: trigger and clear on the same edge
    @(negedge clk) pads[5] = 1'b0;
    cfg_pin(5, 1'b1, 1'b0, 1'b1, 1'b1);
    wait_cyc(4);
    bus_write(12'hE05, 8'h01);
    @(negedge clk) pads[5] = 1'b1;
    wait_cyc(5);
    read_sts(5, rd); check("R9 pre-collision status", rd, 1);
    @(negedge clk) pads[5] = 1'b0;
    @(negedge clk);
    bus_write(12'hE05, 8'h01);
    wait_cyc(2);
    read_sts(5, rd); check("R9 trigger wins over clear", rd, 1);
    bus_write(12'hE05, 8'h01);
    wait_cyc(2);
    read_sts(5, rd); check("R9 plain clear", rd, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule